// File: doc/BRIEF.md
# Halfword-Swapping DMA Address Path

This block sits between a 16-bit network peripheral and a memory port and turns the peripheral's DMA requests into memory beats. A request carries a peripheral-relative byte address, a byte length, a direction and a flag that turns swapping off. When the request is taken, the address is combined with a high-address base input by bitwise OR, not by addition. The block then moves the bytes between a byte stream on the peripheral side and a 16-bit memory port. On a write the bytes come in from the peripheral; on a read they go out to it.

With swapping on, the transfer is first forced to even alignment: bit 0 of the bus address and bit 0 of the length are cleared. The two bytes of every halfword are then exchanged in both directions. Swapped writes go out as a series of bursts of at most `CHUNK` bytes, and each burst continues where the previous one ended. With swapping off, bytes pass through unchanged at the exact address and length asked for, and odd edges use single-lane beats.

All three data interfaces use valid/ready handshakes and tolerate back-pressure. A request is taken only when `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. A write byte moves when `wr_valid` and `wr_ready` are both high. A read byte moves when `rd_valid` and `rd_ready` are both high, and `rd_data` is held until it is taken. A memory beat is presented on `mem_req` and stays unchanged until `mem_gnt`. For reads, `mem_rdata` must be valid in the cycle of the grant.

Top module: `halfswap_dma_path`

## Requirements
- R1: The memory address of the first beat is the request address ORed bitwise with `base_addr`, with bit 0 forced to zero on the port.
- R2: With `req_noswap` high, stream byte i is stored at, or read from, byte address (request address OR base) + i, for exactly `req_len` bytes.
- R3: With `req_noswap` low, bit 0 of the combined address and bit 0 of the length are cleared before the transfer starts.
- R4: With `req_noswap` low, stream byte i maps to memory byte address A XOR 1, where A is the aligned address + i. This holds for both reads and writes.
- R5: Swapped writes are split into bursts of at most `CHUNK` (default 64) bytes. `mem_last` marks the final beat of each burst, and burst k starts at the aligned address + k*`CHUNK`.
- R6: Reads and unswapped writes form one single burst, whatever the length, with `mem_last` only on the final beat.
- R7: A request whose effective length is zero (length 0, or length 1 with swapping on) makes no memory beat and raises `done` in the cycle after it is accepted.
- R8: `done` is a one-cycle pulse after the last byte of a request, and `req_ready` is high only while the block is idle.
- R9: `mem_req`, `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` stay stable until `mem_gnt`. `rd_data` stays stable while `rd_valid` is high and `rd_ready` is low.
- R10: Lane encoding: `mem_wdata[7:0]`/`mem_be[0]` is the even-address byte and `mem_wdata[15:8]`/`mem_be[1]` the odd one. Every beat enables at least one lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | AW | High-address base, ORed into the request address on accept |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_addr | input | AW | Peripheral-relative byte address |
| req_len | input | LW | Byte count |
| req_noswap | input | 1 | 1 = pass bytes straight, 0 = align and swap halfwords |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | input | 1 | Write byte offered by the peripheral |
| wr_ready | output | 1 | Block takes a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered to the peripheral |
| rd_ready | input | 1 | Peripheral takes the read byte |
| rd_data | output | 8 | Read byte |
| mem_req | output | 1 | Memory beat presented |
| mem_gnt | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Halfword-aligned byte address |
| mem_be | output | 2 | Lane enables |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_gnt` |
| mem_last | output | 1 | Final beat of a burst |

## Verification
The bench offers odd addresses and odd lengths in both modes. A design that ignored the alignment rule would touch a byte outside the halfword range or take a byte too many from the stream. Base and address values are chosen so that OR and addition give different results, which catches an adder in place of the OR. A swapped write longer than two chunks checks the burst count and the start address of every burst. A design that chunked reads, or failed to chunk writes, would show the wrong burst count. Zero-length and one-byte swapped requests must finish in one cycle with no beat. Random grant and read-ready stalls catch any beat or byte that changes, or is lost, under back-pressure.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GATHER = 3'd1,
    ST_ISSUE  = 3'd2,
    ST_EMIT   = 3'd3,
    ST_FIN    = 3'd4
  } hsd_state_e;
endpackage

// File: rtl/hsd_req_norm.sv
// Forms the bus address by OR with the base and applies even alignment in swap mode.
module hsd_req_norm #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] req_len,
  input  logic          noswap,
  output logic [AW-1:0] n_addr,
  output logic [LW-1:0] n_len
);
  logic [AW-1:0] merged;

  always_comb begin
    merged = req_addr | base_addr;
    n_addr = {merged[AW-1:1], merged[0] & noswap};
    n_len  = {req_len[LW-1:1], req_len[0] & noswap};
  end
endmodule

// File: rtl/hsd_lane_map.sv
// Places stream bytes on memory lanes and picks read lanes in stream order.
module hsd_lane_map (
  input  logic        swap,
  input  logic        two,
  input  logic        odd,
  input  logic [7:0]  sb0,
  input  logic [7:0]  sb1,
  input  logic [15:0] rdata,
  output logic [15:0] wdata,
  output logic [1:0]  be,
  output logic [7:0]  rb0,
  output logic [7:0]  rb1
);
  always_comb begin
    if (swap) begin
      wdata = {sb0, sb1};
      be    = 2'b11;
      rb0   = rdata[15:8];
      rb1   = rdata[7:0];
    end else if (two) begin
      wdata = {sb1, sb0};
      be    = 2'b11;
      rb0   = rdata[7:0];
      rb1   = rdata[15:8];
    end else begin
      wdata = {sb0, sb0};
      be    = odd ? 2'b10 : 2'b01;
      rb0   = odd ? rdata[15:8] : rdata[7:0];
      rb1   = rb0;
    end
  end
endmodule

// File: rtl/hsd_sequencer.sv
// Beat sequencer: gathers write bytes, issues beats, emits read bytes, tracks bursts.
module hsd_sequencer
  import hsd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int CHUNK = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] n_addr,
  input  logic [LW-1:0] n_len,
  input  logic          n_swap,
  output logic          done,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [7:0]    rd_data,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          mem_last,
  output logic          lm_swap,
  output logic          lm_two,
  output logic          lm_odd,
  output logic [7:0]    hold0,
  output logic [7:0]    hold1,
  input  logic [7:0]    rb0,
  input  logic [7:0]    rb1
);
  localparam logic [LW-1:0] CHUNK_L = LW'(CHUNK);
  localparam logic [LW-1:0] ONE_L   = LW'(1);
  localparam logic [LW-1:0] TWO_L   = LW'(2);

  hsd_state_e    state;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] rem;
  logic [LW-1:0] chunk_left;
  logic          is_wr;
  logic          is_swap;
  logic          idx;
  logic [LW-1:0] beat_n;
  logic [LW-1:0] rem_after;
  logic          beat_done;

  function automatic logic [LW-1:0] burst_of(input logic [LW-1:0] left,
                                             input logic sw, input logic wr);
    if (sw && wr && (left > CHUNK_L)) return CHUNK_L;
    return left;
  endfunction

  always_comb begin
    lm_swap   = is_swap;
    lm_two    = is_swap || (!cur_addr[0] && (rem >= TWO_L));
    lm_odd    = cur_addr[0];
    beat_n    = lm_two ? TWO_L : ONE_L;
    rem_after = rem - beat_n;
    req_ready = (state == ST_IDLE);
    done      = (state == ST_FIN);
    wr_ready  = (state == ST_GATHER);
    rd_valid  = (state == ST_EMIT);
    rd_data   = idx ? hold1 : hold0;
    mem_req   = (state == ST_ISSUE);
    mem_we    = is_wr;
    mem_addr  = {cur_addr[AW-1:1], 1'b0};
    mem_last  = mem_req && (chunk_left == beat_n);
    // a beat finishes on grant for writes, on the last emitted byte for reads
    beat_done = (is_wr  && (state == ST_ISSUE) && mem_gnt) ||
                (!is_wr && (state == ST_EMIT) && rd_ready && (idx == lm_two));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      rem        <= '0;
      chunk_left <= '0;
      is_wr      <= 1'b0;
      is_swap    <= 1'b0;
      idx        <= 1'b0;
      hold0      <= '0;
      hold1      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr   <= n_addr;
            rem        <= n_len;
            is_wr      <= req_write;
            is_swap    <= n_swap;
            idx        <= 1'b0;
            chunk_left <= burst_of(n_len, n_swap, req_write);
            if (n_len == '0)   state <= ST_FIN;
            else if (req_write) state <= ST_GATHER;
            else                state <= ST_ISSUE;
          end
        end
        ST_GATHER: begin
          if (wr_valid) begin
            if (idx) hold1 <= wr_data;
            else     hold0 <= wr_data;
            if (idx == lm_two) begin
              idx   <= 1'b0;
              state <= ST_ISSUE;
            end else begin
              idx <= 1'b1;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_gnt && !is_wr) begin
            hold0 <= rb0;
            hold1 <= rb1;
            idx   <= 1'b0;
            state <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (rd_ready && (idx != lm_two)) idx <= 1'b1;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase

      if (beat_done) begin
        cur_addr <= cur_addr + AW'(beat_n);
        rem      <= rem_after;
        idx      <= 1'b0;
        if (chunk_left == beat_n) chunk_left <= burst_of(rem_after, is_swap, is_wr);
        else                      chunk_left <= chunk_left - beat_n;
        if (rem_after == '0) state <= ST_FIN;
        else if (is_wr)      state <= ST_GATHER;
        else                 state <= ST_ISSUE;
      end
    end
  end
endmodule

// File: rtl/halfswap_dma_path.sv
module halfswap_dma_path #(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int CHUNK = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_noswap,
  output logic          done,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [7:0]    rd_data,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          mem_last
);
  logic [AW-1:0] n_addr;
  logic [LW-1:0] n_len;
  logic          lm_swap, lm_two, lm_odd;
  logic [7:0]    hold0, hold1, rb0, rb1;

  hsd_req_norm #(.AW(AW), .LW(LW)) u_norm (
    .req_addr (req_addr),
    .base_addr(base_addr),
    .req_len  (req_len),
    .noswap   (req_noswap),
    .n_addr   (n_addr),
    .n_len    (n_len)
  );

  hsd_sequencer #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .n_addr   (n_addr),
    .n_len    (n_len),
    .n_swap   (!req_noswap),
    .done     (done),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_data  (wr_data),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .mem_req  (mem_req),
    .mem_gnt  (mem_gnt),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_last (mem_last),
    .lm_swap  (lm_swap),
    .lm_two   (lm_two),
    .lm_odd   (lm_odd),
    .hold0    (hold0),
    .hold1    (hold1),
    .rb0      (rb0),
    .rb1      (rb1)
  );

  hsd_lane_map u_lanes (
    .swap (lm_swap),
    .two  (lm_two),
    .odd  (lm_odd),
    .sb0  (hold0),
    .sb1  (hold1),
    .rdata(mem_rdata),
    .wdata(mem_wdata),
    .be   (mem_be),
    .rb0  (rb0),
    .rb1  (rb1)
  );
endmodule

// File: rtl/hsd_checker.sv
module hsd_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [7:0]    rd_data,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_be,
  input logic [15:0]   mem_wdata,
  input logic          mem_last
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rd_valid && !wr_ready && !done));

  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_be) && (!mem_we || $stable(mem_wdata))));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_lane_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != 2'b00));

  p_last_in_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_last |-> mem_req);
endmodule

bind halfswap_dma_path hsd_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .done     (done),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .mem_req  (mem_req),
  .mem_gnt  (mem_gnt),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .mem_wdata(mem_wdata),
  .mem_last (mem_last)
);

// File: tb/sim_halfswap_dma_path.sv
`timescale 1ns/1ps
module sim_halfswap_dma_path;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int CHUNK = 64;
  localparam int MSZ = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_noswap = 1'b0;
  logic          done;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [7:0]    wr_data = '0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [7:0]    rd_data;
  logic          mem_req;
  logic          mem_gnt = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;
  logic          mem_last;

  always #4 clk = ~clk;

  halfswap_dma_path #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u0 (.*);

  int total = 0;
  int bad = 0;
  logic [7:0] mem [MSZ];
  logic [7:0] ref_mem [MSZ];
  logic [7:0] wr_q[$];
  logic [7:0] exp_q[$];
  int beats, bursts, first_addr;
  bit new_burst;
  int bstart[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory model, write-stream driver and read-stream monitor (scoreboard)
  always @(negedge clk) begin
    logic [9:0] a;
    a = mem_addr[9:0];
    mem_gnt   = mem_req && ($urandom_range(0, 3) != 0);
    mem_rdata = {mem[{a[9:1], 1'b1}], mem[{a[9:1], 1'b0}]};
    rd_ready  = ($urandom_range(0, 2) != 0);
    wr_valid  = (wr_q.size() > 0) && ($urandom_range(0, 3) != 0);
    wr_data   = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
    #1;
    if (mem_req && mem_gnt) begin
      if (beats == 0) first_addr = int'(mem_addr);
      if (new_burst) begin
        bstart.push_back(int'(mem_addr));
        new_burst = 1'b0;
      end
      beats++;
      if (mem_last) begin
        bursts++;
        new_burst = 1'b1;
      end
      if (mem_we) begin
        if (mem_be[0]) mem[{a[9:1], 1'b0}] = mem_wdata[7:0];
        if (mem_be[1]) mem[{a[9:1], 1'b1}] = mem_wdata[15:8];
      end
    end
    if (wr_valid && wr_ready) void'(wr_q.pop_front());
    if (rd_valid && rd_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected read byte", rd_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R4", "read byte", rd_data, e);
      end
    end
  end

  task automatic run_req(input bit wr, input int addr, input int len, input bit noswap,
                         input int exp_bursts, input string tag);
    int eaddr, elen, cyc, idle_hi, mism;
    eaddr = (addr | int'(base_addr));
    elen  = len;
    if (!noswap) begin
      eaddr = eaddr & ~1;
      elen  = elen & ~1;
    end
    beats = 0; bursts = 0; new_burst = 1'b1; bstart.delete();
    for (int i = 0; i < elen; i++) begin
      int p;
      p = noswap ? ((eaddr + i) % MSZ) : (((eaddr + i) ^ 1) % MSZ);
      if (wr) begin
        logic [7:0] b;
        b = 8'($urandom_range(0, 255));
        ref_mem[p] = b;
        wr_q.push_back(b);
      end else begin
        exp_q.push_back(ref_mem[p]);
      end
    end
    @(negedge clk);
    req_write = wr; req_addr = AW'(addr); req_len = LW'(len);
    req_noswap = noswap; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; idle_hi = 0;
    #1;
    while (!done) begin
      if (req_ready) idle_hi++;
      @(negedge clk); #1; cyc++;
    end
    chk(idle_hi == 0, "R8", "req_ready high while busy", idle_hi, 0);
    @(negedge clk); #1;
    chk(!done && req_ready, "R8", "done pulse width / idle after done", {done, req_ready}, 2'b01);
    chk(bursts == exp_bursts, tag, "burst count", bursts, exp_bursts);
    if (elen == 0) begin
      chk(beats == 0, "R7", "beats on empty request", beats, 0);
      chk(cyc == 1, "R7", "cycles to done", cyc, 1);
    end else begin
      chk(first_addr == (eaddr & ~1), "R1", "first beat address", first_addr, eaddr & ~1);
    end
    if (wr && !noswap) begin
      for (int k = 0; k < bstart.size(); k++)
        chk(bstart[k] == ((eaddr & ~1) + k * CHUNK), "R5", "burst start", bstart[k],
            (eaddr & ~1) + k * CHUNK);
    end
    if (wr) begin
      mism = 0;
      for (int i = 0; i < MSZ; i++) if (mem[i] !== ref_mem[i]) mism++;
      chk(mism == 0, noswap ? "R2" : "R4", "memory bytes differing", mism, 0);
      chk(wr_q.size() == 0, "R3", "write bytes left unconsumed", wr_q.size(), 0);
    end else begin
      chk(exp_q.size() == 0, "R3", "read bytes missing", exp_q.size(), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < MSZ; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    #1;
    chk(req_ready && !done && !mem_req && !rd_valid && !wr_ready, "R8", "reset state",
        {req_ready, done, mem_req, rd_valid, wr_ready}, 5'b10000);
    rst_n = 1'b1;
    base_addr = 32'h0000_0200;
    // R2 R10: unswapped odd start, odd length, single-lane edges
    run_req(1, 32'h011, 7, 1, 1, "R6");
    run_req(0, 32'h011, 7, 1, 1, "R6");
    // R3 R4: swapped with odd address and length
    run_req(1, 32'h041, 9, 0, 1, "R5");
    run_req(0, 32'h041, 9, 0, 1, "R6");
    run_req(0, 32'h010, 12, 0, 1, "R6");
    // R5: long swapped write split into chunks
    run_req(1, 32'h080, 150, 0, 3, "R5");
    run_req(0, 32'h080, 150, 0, 1, "R6");
    // R6: long unswapped write is one burst
    run_req(1, 32'h101, 100, 1, 1, "R6");
    run_req(0, 32'h0FF, 130, 0, 1, "R6");
    // R7: empty requests
    run_req(1, 32'h021, 1, 0, 0, "R7");
    run_req(0, 32'h021, 0, 0, 0, "R7");
    run_req(1, 32'h021, 0, 1, 0, "R7");
    // R2: single byte unswapped at odd address
    run_req(1, 32'h033, 1, 1, 1, "R2");
    // R1: OR, not add (0x300 | 0x120 = 0x320, sum would be 0x420)
    base_addr = 32'h0000_0300;
    run_req(0, 32'h120, 6, 1, 1, "R1");
    run_req(1, 32'h121, 5, 0, 1, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired R8 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule